// File: doc/BRIEF.md
# Dual-Port Address-Collision Busy Arbiter

This block sits between two independent ports of a shared word store, called left and right. Each port offers an enable, a word address, a write strobe and a byte-lane mask. When both ports select the same word at once, the block grants the word to one port and drives an active-low busy flag toward the other. The loser's write is stopped inside the block, so the per-port byte write masks it hands to the array never carry a blocked write.

A mode input sets the role. As master, the block decides the collision and drives its busy outputs. As slave, its own decision is not shown on the busy outputs. Two external busy inputs are used only to block writes on their ports, so several copies can widen a word while one master decides. The block has one clock domain. All port inputs are registered. Busy and the write masks appear together two clocks after the inputs that caused them.

The decision depends only on enables and addresses. A port that was already enabled on a word in the previous cycle wins against a port that arrives on that word later. A same-cycle tie goes to the left port. The winner keeps the grant for as long as the collision lasts.

Top module: `dpa_collide_arb`

## Requirements
- R1: When the registered inputs show either port disabled or the two addresses unequal, both busy outputs are high (inactive).
- R2: The write strobes play no part in the arbitration. Swapping which port reads and which writes leaves the busy outcome unchanged.
- R3: When one port was already enabled on the same address in the previous cycle and the other port newly matches it, the earlier port wins and the later port gets busy low.
- R4: The two busy outputs are never low at the same time.
- R5: When both ports begin a matching access in the same cycle, the left port wins and the right busy output goes low.
- R6: In master mode, a port whose busy is low has an all-zero write mask, whatever its strobe and byte mask show.
- R7: In slave mode (master_i = 0), both busy outputs stay high. A port whose external busy input is low has an all-zero write mask.
- R8: Busy on the losing port returns high once the addresses differ or either enable goes low.
- R9: While a collision lasts, the port that won keeps the grant, even if the other port changes its byte mask or strobe.
- R10: After reset both busy outputs are high and both write masks are zero. Every output reflects the inputs sampled two rising edges earlier. A port that is not blocked and has enable and strobe high outputs its byte mask as its write mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master (decides, drives busy), 0 = slave |
| l_en_i | input | 1 | Left port enable, active high |
| l_addr_i | input | AW | Left port word address |
| l_wr_i | input | 1 | Left port write strobe, active high |
| l_be_i | input | NB | Left port byte-lane mask |
| r_en_i | input | 1 | Right port enable, active high |
| r_addr_i | input | AW | Right port word address |
| r_wr_i | input | 1 | Right port write strobe, active high |
| r_be_i | input | NB | Right port byte-lane mask |
| l_busy_in_n_i | input | 1 | External busy for left port, used in slave mode, active low |
| r_busy_in_n_i | input | 1 | External busy for right port, used in slave mode, active low |
| l_busy_n_o | output | 1 | Busy toward left port, active low |
| r_busy_n_o | output | 1 | Busy toward right port, active low |
| l_we_o | output | NB | Gated byte write mask of the left port |
| r_we_o | output | NB | Gated byte write mask of the right port |

## Verification
The bench targets the order of arrival. It covers a port that settles on a word one cycle before the other, a same-cycle tie, and a loser that keeps changing its byte mask during a long collision. A design that judged by strobe instead of by arrival, or that re-arbitrated every cycle, would move busy to the wrong port or toggle it while the collision lasts. A design that gated writes one cycle late would let the loser's mask through on the first collided cycle. A slave that still showed its own decision, or that ignored the external busy, would show busy outputs or write masks that disagree with the expected values.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
   // who currently holds the contested word
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } own_e;
endpackage

// File: rtl/dpa_port_stage.sv
// Input register of one port plus the one-cycle history used to tell
// whether the port was already sitting on its word before a match.
module dpa_port_stage #(
   parameter int AW = 8,
   parameter int NB = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic [AW-1:0] addr_i,
   input  logic          wr_i,
   input  logic [NB-1:0] be_i,
   input  logic          bin_n_i,
   output logic          en_o,
   output logic [AW-1:0] addr_o,
   output logic          wr_o,
   output logic [NB-1:0] be_o,
   output logic          bin_n_o,
   output logic          settled_o
);
   logic          en_hist;
   logic [AW-1:0] addr_hist;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o      <= 1'b0;
         addr_o    <= '0;
         wr_o      <= 1'b0;
         be_o      <= '0;
         bin_n_o   <= 1'b1;
         en_hist   <= 1'b0;
         addr_hist <= '0;
      end else begin
         en_o      <= en_i;
         addr_o    <= addr_i;
         wr_o      <= wr_i;
         be_o      <= be_i;
         bin_n_o   <= bin_n_i;
         en_hist   <= en_o;
         addr_hist <= addr_o;
      end
   end

   // enabled on this same word one cycle earlier as well
   assign settled_o = en_o & en_hist & (addr_o == addr_hist);
endmodule

// File: rtl/dpa_arb_core.sv
// Collision detect and grant keeping; registered busy flags.
module dpa_arb_core #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          master_i,
   input  logic          l_en_i,
   input  logic [AW-1:0] l_addr_i,
   input  logic          l_settled_i,
   input  logic          r_en_i,
   input  logic [AW-1:0] r_addr_i,
   input  logic          r_settled_i,
   input  logic          l_bin_n_i,
   input  logic          r_bin_n_i,
   output logic          l_busy_n_o,
   output logic          r_busy_n_o,
   output logic [1:0]    inhibit_o
);
   import dpa_pkg::*;

   own_e owner_q, owner_nxt;
   logic hit;

   assign hit = l_en_i & r_en_i & (l_addr_i == r_addr_i);

   always_comb begin
      owner_nxt = owner_q;
      if (!hit)
         owner_nxt = OWN_NONE;
      else if (owner_q == OWN_NONE) begin
         if (r_settled_i && !l_settled_i) owner_nxt = OWN_RIGHT;
         else                             owner_nxt = OWN_LEFT;  // earlier left or tie
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q    <= OWN_NONE;
         l_busy_n_o <= 1'b1;
         r_busy_n_o <= 1'b1;
      end else begin
         owner_q    <= owner_nxt;
         l_busy_n_o <= ~(master_i & (owner_nxt == OWN_RIGHT));
         r_busy_n_o <= ~(master_i & (owner_nxt == OWN_LEFT));
      end
   end

   // inhibit for the write gate, aligned with the busy flop inputs
   assign inhibit_o[0] = master_i ? (owner_nxt == OWN_RIGHT) : ~l_bin_n_i;
   assign inhibit_o[1] = master_i ? (owner_nxt == OWN_LEFT)  : ~r_bin_n_i;
endmodule

// File: rtl/dpa_wr_gate.sv
// Registered byte write mask toward the array, cut by the inhibit.
module dpa_wr_gate #(
   parameter int NB = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          wr_i,
   input  logic [NB-1:0] be_i,
   input  logic          inhibit_i,
   output logic [NB-1:0] we_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        we_o <= '0;
      else if (en_i & wr_i & ~inhibit_i) we_o <= be_i;
      else                               we_o <= '0;
   end
endmodule

// File: rtl/dpa_collide_arb.sv
module dpa_collide_arb #(
   parameter int AW = 8,
   parameter int NB = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          master_i,
   input  logic          l_en_i,
   input  logic [AW-1:0] l_addr_i,
   input  logic          l_wr_i,
   input  logic [NB-1:0] l_be_i,
   input  logic          r_en_i,
   input  logic [AW-1:0] r_addr_i,
   input  logic          r_wr_i,
   input  logic [NB-1:0] r_be_i,
   input  logic          l_busy_in_n_i,
   input  logic          r_busy_in_n_i,
   output logic          l_busy_n_o,
   output logic          r_busy_n_o,
   output logic [NB-1:0] l_we_o,
   output logic [NB-1:0] r_we_o
);
   localparam int NP = 2;   // index 0 = left, 1 = right

   if (AW < 1) begin : g_bad_aw
      $error("dpa_collide_arb: AW must be at least 1");
   end
   if (NB < 1) begin : g_bad_nb
      $error("dpa_collide_arb: NB must be at least 1");
   end

   logic [NP-1:0] en_in, wr_in, bin_in;
   logic [AW-1:0] addr_in [NP];
   logic [NB-1:0] be_in   [NP];
   logic [NP-1:0] en_q, wr_q, bin_q, settled;
   logic [AW-1:0] addr_q  [NP];
   logic [NB-1:0] be_q    [NP];
   logic [NB-1:0] we      [NP];
   logic [NP-1:0] inhibit;
   logic          master_q;

   assign en_in   = {r_en_i, l_en_i};
   assign wr_in   = {r_wr_i, l_wr_i};
   assign bin_in  = {r_busy_in_n_i, l_busy_in_n_i};
   assign addr_in[0] = l_addr_i;
   assign addr_in[1] = r_addr_i;
   assign be_in[0]   = l_be_i;
   assign be_in[1]   = r_be_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) master_q <= 1'b0;
      else        master_q <= master_i;
   end

   for (genvar p = 0; p < NP; p++) begin : g_port
      dpa_port_stage #(.AW(AW), .NB(NB)) u_stage (
         .clk       (clk),
         .rst_n     (rst_n),
         .en_i      (en_in[p]),
         .addr_i    (addr_in[p]),
         .wr_i      (wr_in[p]),
         .be_i      (be_in[p]),
         .bin_n_i   (bin_in[p]),
         .en_o      (en_q[p]),
         .addr_o    (addr_q[p]),
         .wr_o      (wr_q[p]),
         .be_o      (be_q[p]),
         .bin_n_o   (bin_q[p]),
         .settled_o (settled[p])
      );

      dpa_wr_gate #(.NB(NB)) u_gate (
         .clk       (clk),
         .rst_n     (rst_n),
         .en_i      (en_q[p]),
         .wr_i      (wr_q[p]),
         .be_i      (be_q[p]),
         .inhibit_i (inhibit[p]),
         .we_o      (we[p])
      );
   end

   dpa_arb_core #(.AW(AW)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .master_i    (master_q),
      .l_en_i      (en_q[0]),
      .l_addr_i    (addr_q[0]),
      .l_settled_i (settled[0]),
      .r_en_i      (en_q[1]),
      .r_addr_i    (addr_q[1]),
      .r_settled_i (settled[1]),
      .l_bin_n_i   (bin_q[0]),
      .r_bin_n_i   (bin_q[1]),
      .l_busy_n_o  (l_busy_n_o),
      .r_busy_n_o  (r_busy_n_o),
      .inhibit_o   (inhibit)
   );

   assign l_we_o = we[0];
   assign r_we_o = we[1];
endmodule

// File: rtl/dpa_collide_arb_chk.sv
module dpa_collide_arb_chk #(
   parameter int AW = 8,
   parameter int NB = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          master_i,
   input logic          l_en_i,
   input logic [AW-1:0] l_addr_i,
   input logic          l_wr_i,
   input logic [NB-1:0] l_be_i,
   input logic          r_en_i,
   input logic [AW-1:0] r_addr_i,
   input logic          r_wr_i,
   input logic [NB-1:0] r_be_i,
   input logic          l_busy_in_n_i,
   input logic          r_busy_in_n_i,
   input logic          l_busy_n_o,
   input logic          r_busy_n_o,
   input logic [NB-1:0] l_we_o,
   input logic [NB-1:0] r_we_o
);
   p_never_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!l_busy_n_o && !r_busy_n_o));

   p_idle_no_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(l_en_i, 2) || !$past(r_en_i, 2) || ($past(l_addr_i, 2) != $past(r_addr_i, 2)))
      |-> (l_busy_n_o && r_busy_n_o));

   p_left_loser_dry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !l_busy_n_o |-> (l_we_o == '0));

   p_right_loser_dry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !r_busy_n_o |-> (r_we_o == '0));

   p_slave_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(master_i, 2) |-> (l_busy_n_o && r_busy_n_o));

   p_slave_block_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(master_i, 2) && !$past(l_busy_in_n_i, 2)) |-> (l_we_o == '0));

   p_slave_block_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(master_i, 2) && !$past(r_busy_in_n_i, 2)) |-> (r_we_o == '0));
endmodule

bind dpa_collide_arb dpa_collide_arb_chk #(.AW(AW), .NB(NB)) u_chk (.*);

// File: tb/test_dpa_collide_arb.sv
`timescale 1ns/1ps
module test_dpa_collide_arb;
   localparam int AW = 8;
   localparam int NB = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          master_i = 1'b1;
   logic          l_en_i = 0, r_en_i = 0, l_wr_i = 0, r_wr_i = 0;
   logic [AW-1:0] l_addr_i = '0, r_addr_i = '0;
   logic [NB-1:0] l_be_i = '0, r_be_i = '0;
   logic          l_busy_in_n_i = 1'b1, r_busy_in_n_i = 1'b1;
   logic          l_busy_n_o, r_busy_n_o;
   logic [NB-1:0] l_we_o, r_we_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   dpa_collide_arb #(.AW(AW), .NB(NB)) i_dpa_collide_arb (.*);

   // reference state
   int            m_owner = 0;          // 0 none, 1 left holds, 2 right holds
   logic          m_pen [2] = '{1'b0, 1'b0};
   logic [AW-1:0] m_paddr [2] = '{'0, '0};
   string         dtag = "";

   // expectation pipeline, two stages deep
   logic          e1_bl = 1, e1_br = 1, e2_bl = 1, e2_br = 1;
   logic [NB-1:0] e1_wl = '0, e1_wr = '0, e2_wl = '0, e2_wr = '0;
   string         e1_tb = "R10", e1_tw = "R10", e2_tb = "R10", e2_tw = "R10";

   function automatic logic [NB-1:0] gate_mask(logic en, logic wr, logic blk,
                                               logic [NB-1:0] be);
      return (en && wr && !blk) ? be : '0;
   endfunction

   task automatic model_update();
      logic hit, ls, rs, il, ir;
      string tb, tw;
      hit = l_en_i && r_en_i && (l_addr_i == r_addr_i);
      ls  = l_en_i && m_pen[0] && (l_addr_i == m_paddr[0]);
      rs  = r_en_i && m_pen[1] && (r_addr_i == m_paddr[1]);
      if (!hit) begin
         tb = (m_owner != 0) ? "R8" : "R1";
         m_owner = 0;
      end else if (m_owner != 0) begin
         tb = "R9";
      end else if (rs && !ls) begin
         m_owner = 2; tb = "R3";
      end else begin
         m_owner = 1; tb = ls ? "R3" : "R5";
      end
      if (!master_i) tb = "R7";
      if (dtag != "") tb = dtag;
      il = master_i ? (m_owner == 2) : !l_busy_in_n_i;
      ir = master_i ? (m_owner == 1) : !r_busy_in_n_i;
      tw = (il || ir) ? (master_i ? "R6" : "R7") : "R10";
      e1_bl = !(master_i && m_owner == 2);
      e1_br = !(master_i && m_owner == 1);
      e1_wl = gate_mask(l_en_i, l_wr_i, il, l_be_i);
      e1_wr = gate_mask(r_en_i, r_wr_i, ir, r_be_i);
      e1_tb = tb;
      e1_tw = tw;
      m_pen[0] = l_en_i;  m_paddr[0] = l_addr_i;
      m_pen[1] = r_en_i;  m_paddr[1] = r_addr_i;
   endtask

   task automatic check_now();
      n_tests++;
      if ({l_busy_n_o, r_busy_n_o} !== {e2_bl, e2_br}) begin
         n_fail++;
         $display("FAIL %s busy l/r actual %b%b expected %b%b", e2_tb,
                  l_busy_n_o, r_busy_n_o, e2_bl, e2_br);
      end
      n_tests++;
      if ({l_we_o, r_we_o} !== {e2_wl, e2_wr}) begin
         n_fail++;
         $display("FAIL %s write masks l/r actual %h/%h expected %h/%h", e2_tw,
                  l_we_o, r_we_o, e2_wl, e2_wr);
      end
      n_tests++;
      if (!l_busy_n_o && !r_busy_n_o) begin   // R4
         n_fail++;
         $display("FAIL R4 both busy low actual 00 expected not 00");
      end
   endtask

   task automatic step(input logic m, input logic le, input logic [AW-1:0] la,
                       input logic lw, input logic [NB-1:0] lb,
                       input logic re, input logic [AW-1:0] ra,
                       input logic rw, input logic [NB-1:0] rb,
                       input logic bl, input logic br);
      @(negedge clk);
      check_now();
      e2_bl = e1_bl; e2_br = e1_br; e2_wl = e1_wl; e2_wr = e1_wr;
      e2_tb = e1_tb; e2_tw = e1_tw;
      master_i = m;
      l_en_i = le; l_addr_i = la; l_wr_i = lw; l_be_i = lb;
      r_en_i = re; r_addr_i = ra; r_wr_i = rw; r_be_i = rb;
      l_busy_in_n_i = bl; r_busy_in_n_i = br;
      model_update();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      // R10: reset state is checked by the first steps (expect busy high, masks 0)
      @(negedge clk);
      rst_n = 1'b1;
      idle(3);

      // R5: tie, both write word 5 in the same cycle -> left wins
      step(1, 1, 8'h05, 1, 2'b11, 1, 8'h05, 1, 2'b11, 1, 1);
      // R9: collision lasts, right keeps changing its byte mask
      step(1, 1, 8'h05, 1, 2'b01, 1, 8'h05, 1, 2'b10, 1, 1);
      step(1, 1, 8'h05, 1, 2'b10, 1, 8'h05, 1, 2'b01, 1, 1);
      // R8: right moves away
      step(1, 1, 8'h05, 1, 2'b11, 1, 8'h06, 1, 2'b11, 1, 1);
      idle(2);

      // R3: right settles on word 9 first, left arrives later -> right wins
      step(1, 0, 8'h00, 0, 2'b00, 1, 8'h09, 0, 2'b00, 1, 1);
      step(1, 1, 8'h09, 1, 2'b11, 1, 8'h09, 1, 2'b11, 1, 1);
      step(1, 1, 8'h09, 1, 2'b11, 1, 8'h09, 1, 2'b11, 1, 1);
      // R8: left disables
      step(1, 0, 8'h09, 1, 2'b11, 1, 8'h09, 1, 2'b11, 1, 1);
      idle(2);

      // R2: tie with left write / right read, then left read / right write
      dtag = "R2";
      step(1, 1, 8'h20, 1, 2'b11, 1, 8'h20, 0, 2'b11, 1, 1);
      idle(2);
      dtag = "R2";
      step(1, 1, 8'h20, 0, 2'b11, 1, 8'h20, 1, 2'b11, 1, 1);
      dtag = "";
      idle(3);

      // R7: slave, collision, right blocked from outside, left writes freely
      step(0, 1, 8'h30, 1, 2'b11, 1, 8'h30, 1, 2'b10, 1, 0);
      step(0, 1, 8'h30, 1, 2'b01, 1, 8'h30, 1, 2'b11, 0, 1);
      step(0, 1, 8'h31, 1, 2'b11, 1, 8'h32, 1, 2'b11, 1, 1);
      idle(3);

      // random phase
      for (int k = 0; k < 3000; k++) begin
         logic m, le, lw, re, rw, bl, br;
         logic [AW-1:0] la, ra;
         logic [NB-1:0] lb, rb;
         m  = ($urandom_range(9) != 0);
         bl = ($urandom_range(3) != 0);
         br = ($urandom_range(3) != 0);
         if ($urandom_range(1) == 0) begin
            le = l_en_i; la = l_addr_i; lw = l_wr_i; lb = l_be_i;
         end else begin
            le = ($urandom_range(3) != 0); la = AW'($urandom_range(3));
            lw = $urandom_range(1) != 0;  lb = NB'($urandom);
         end
         if ($urandom_range(1) == 0) begin
            re = r_en_i; ra = r_addr_i; rw = r_wr_i; rb = r_be_i;
         end else begin
            re = ($urandom_range(3) != 0); ra = AW'($urandom_range(3));
            rw = $urandom_range(1) != 0;  rb = NB'($urandom);
         end
         step(m, le, la, lw, lb, re, ra, rw, rb, bl, br);
      end
      idle(3);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule